// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave-side front end of a byte-addressed serial memory. It receives a mode-0 serial stream (clock idle low, input taken on the rising clock edge, output moved on the falling edge), most significant bit first, with each transaction opened by chip select going low. The first byte is an instruction. It is followed by address and data bytes where the instruction calls for them. Read data or status then streams back on the output line.

Six instructions are recognised: arm writes, disarm writes, status read, status write, array read and array write. Array reads are served from an external byte-array model through a read port. Status reads return the word that a separate status and protection unit presents. Written array bytes are collected in a small buffer and are issued to the array model only after the transaction closes cleanly, one byte per clock. A per-byte grant input lets the protection unit refuse individual addresses. The write-arm latch lives in this block and is exported so the status unit can report it.

Serial inputs pass through a synchronizer into the system clock domain. The serial clock must therefore be slow compared with the system clock: each serial clock phase needs to last at least six system clock cycles.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset the write-arm output `wel` is 0, `miso_oe` is 0 and no array or status write is issued.
- R2: `miso_oe` is 1 while chip select is low and 0 while it is high; after deselection the output data line returns to 0.
- R3: The instruction byte is decoded with bit 3 ignored and the upper nibble required to be 0000; the low three bits select 110 arm, 100 disarm, 101 status read, 001 status write, 011 array read, 010 array write.
- R4: An arm or disarm instruction sets or clears `wel` when chip select rises after a whole number of bytes; disarm acts regardless of `stat_wr_ok`.
- R5: An array write sent while `wel` is 0 issues no array write.
- R6: An array read takes a 16-bit address, keeps only its low 13 bits, and returns the byte at that address MSB first, then the bytes at following addresses for as long as chip select stays low.
- R7: A read stream wraps from address 0x1FFF to 0x0000.
- R8: An armed array write commits its data bytes, in order, to consecutive addresses after chip select rises on a byte boundary, and `wel` is 0 from then on.
- R9: If chip select rises partway through a byte, no array or status write is issued and `wel` keeps its value.
- R10: During a commit, a byte whose address has `prot_ok` low is skipped while the other bytes are still written.
- R11: An armed status write pulses `stat_we` for one cycle with the first data byte on `stat_wdata` when `stat_wr_ok` is 1, and issues nothing when it is 0; either way `wel` is cleared. A status read returns `stat_rdata` unchanged, and repeats it for every further byte.
- R12: An unrecognised instruction byte causes nothing until chip select rises: the output data line stays 0, no write is issued and `wel` is unchanged.
- R13: Only the first 32 data bytes of one array write are kept; later bytes in the same transaction are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for miso (0 means high impedance) |
| wel | output | 1 | Write-arm latch state |
| mem_raddr | output | 13 | Array read address |
| mem_rdata | input | 8 | Array read data |
| mem_we | output | 1 | Array write strobe |
| mem_waddr | output | 13 | Array write address |
| mem_wdata | output | 8 | Array write data |
| prot_ok | input | 1 | Grant for the address on mem_waddr |
| stat_rdata | input | 8 | Status word from the status unit |
| stat_we | output | 1 | Status write strobe |
| stat_wdata | output | 8 | Status write data |
| stat_wr_ok | input | 1 | Grant for status writes |

## Verification
Reads are run with a plain address, with an address whose upper three bits are set, and with a stream that crosses the top of the array. Together they show whether the address is truncated and whether the increment wraps. Writes are tried unarmed, armed, cut short mid-byte, straddling a refused address range and overrunning the buffer. The expected write log then differs for each fault in arming, framing, grant handling or buffer limits. The same instructions are also sent with bit 3 set, along with opcodes that have a nonzero upper nibble or an unused low code. These check that decoding ignores only the don't-care bit.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADH, PH_ADL, PH_RD, PH_WR, PH_SKIP
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_WREN, OP_WRDI, OP_RDSR, OP_WRSR, OP_READ, OP_WRITE
  } op_e;

  // f = {upper nibble, low three bits}; bit 3 of the byte never reaches here
  function automatic op_e op_decode(input logic [6:0] f);
    if (f[6:3] != 4'd0) return OP_NONE;
    case (f[2:0])
      3'b110:  return OP_WREN;
      3'b100:  return OP_WRDI;
      3'b101:  return OP_RDSR;
      3'b001:  return OP_WRSR;
      3'b011:  return OP_READ;
      3'b010:  return OP_WRITE;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic rst_sn,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_act,
  output logic cs_start,
  output logic cs_end,
  output logic mosi_s
);

  logic [1:0]        rst_sh;
  logic [STAGES-1:0] sck_sh, cs_sh, mo_sh;
  logic              sck_d, cs_d;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh <= 2'b00;
    else        rst_sh <= {rst_sh[0], 1'b1};
  end
  assign rst_sn = rst_sh[1];

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sck_sh <= '0;
      cs_sh  <= '1;
      mo_sh  <= '0;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_sh <= {sck_sh[STAGES-2:0], sck_i};
      cs_sh  <= {cs_sh[STAGES-2:0], cs_n_i};
      mo_sh  <= {mo_sh[STAGES-2:0], mosi_i};
      sck_d  <= sck_sh[STAGES-1];
      cs_d   <= cs_sh[STAGES-1];
    end
  end

  assign sck_rise = sck_sh[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_sh[STAGES-1] & sck_d;
  assign cs_act   = ~cs_sh[STAGES-1];
  assign cs_start = ~cs_sh[STAGES-1] & cs_d;
  assign cs_end   = cs_sh[STAGES-1] & ~cs_d;
  assign mosi_s   = mo_sh[STAGES-1];

endmodule

// File: rtl/spi_wr_buf.sv
module spi_wr_buf #(
  parameter int DEPTH = 32,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count
);

  logic [7:0]    store [DEPTH];
  logic [CW-1:0] count_n;
  logic          accept;

  assign accept = push && (count < CW'(DEPTH));

  always_comb begin
    count_n = count;
    if (clr)         count_n = '0;
    else if (accept) count_n = count + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) count <= '0;
    else         count <= count_n;
  end

  always_ff @(posedge clk) begin
    if (accept && !clr) store[count[IW-1:0]] <= push_data;
  end

  assign rd_data = store[rd_idx];

  // R13
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (push && !clr && count == CW'(DEPTH)) |=> $stable(count));

  // R13
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    count <= CW'(DEPTH));

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int AW          = 13,
  parameter int BUF_DEPTH   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  output logic          wel,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  input  logic          prot_ok,
  input  logic [7:0]    stat_rdata,
  output logic          stat_we,
  output logic [7:0]    stat_wdata,
  input  logic          stat_wr_ok
);

  localparam int IW = $clog2(BUF_DEPTH);
  localparam int CW = $clog2(BUF_DEPTH + 1);

  logic rst_sn, sck_rise, sck_fall, cs_act, cs_start, cs_end, mosi_s;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .rst_sn(rst_sn), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
  );

  phase_e        phase_q, phase_n;
  op_e           op_q, op_n, dec;
  logic [2:0]    bitcnt_q, bitcnt_n, txcnt_q, txcnt_n;
  logic [6:0]    rx_q, rx_n;
  logic [7:0]    tx_q, tx_n, rx_byte;
  logic [AW-1:0] addr_q, addr_n, cm_base_q, cm_base_n;
  logic          miso_q, miso_n, tx_live_q, tx_live_n, load_q, load_n;
  logic          wel_q, wel_n, cm_busy_q, cm_busy_n, stat_we_q, stat_we_n;
  logic [IW-1:0] cm_idx_q, cm_idx_n;
  logic [CW-1:0] cm_cnt_q, cm_cnt_n, buf_count;
  logic          buf_push, buf_clr, byte_done, armed_wr;
  logic [7:0]    buf_rdata;

  spi_wr_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_sn(rst_sn), .clr(buf_clr), .push(buf_push),
    .push_data(rx_byte), .rd_idx(cm_busy_q ? cm_idx_q : '0),
    .rd_data(buf_rdata), .count(buf_count)
  );

  assign rx_byte   = {rx_q, mosi_s};
  assign byte_done = sck_rise && (bitcnt_q == 3'd7);
  assign armed_wr  = (phase_q == PH_WR) && wel_q && (buf_count != '0);
  assign dec       = op_decode({rx_byte[7:4], rx_byte[2:0]});

  always_comb begin
    phase_n = phase_q;  op_n = op_q;       bitcnt_n = bitcnt_q;
    txcnt_n = txcnt_q;  rx_n = rx_q;       tx_n = tx_q;
    addr_n = addr_q;    miso_n = miso_q;   tx_live_n = tx_live_q;
    load_n = load_q;    wel_n = wel_q;     cm_busy_n = cm_busy_q;
    cm_idx_n = cm_idx_q; cm_cnt_n = cm_cnt_q; cm_base_n = cm_base_q;
    stat_we_n = 1'b0;   buf_push = 1'b0;   buf_clr = 1'b0;

    if (cm_busy_q) begin
      cm_idx_n = cm_idx_q + IW'(1);
      if (CW'(cm_idx_q) + CW'(1) == cm_cnt_q) cm_busy_n = 1'b0;
    end

    if (cs_start) begin
      phase_n = PH_OPC;  op_n = OP_NONE; bitcnt_n = '0;
      tx_live_n = 1'b0;  load_n = 1'b0;  miso_n = 1'b0;
      buf_clr = 1'b1;
    end else if (cs_end) begin
      if (bitcnt_q == 3'd0) begin
        unique case (op_q)
          OP_WREN: wel_n = 1'b1;
          OP_WRDI: wel_n = 1'b0;
          OP_WRITE: if (armed_wr) begin
            wel_n = 1'b0;       cm_busy_n = 1'b1;   cm_idx_n = '0;
            cm_cnt_n = buf_count; cm_base_n = addr_q;
          end
          OP_WRSR: if (armed_wr) begin
            wel_n = 1'b0;
            stat_we_n = stat_wr_ok;
          end
          default: ;
        endcase
      end
      phase_n = PH_OPC;  op_n = OP_NONE;
      tx_live_n = 1'b0;  load_n = 1'b0;  miso_n = 1'b0;
    end else if (cs_act) begin
      if (sck_rise) begin
        bitcnt_n = bitcnt_q + 3'd1;
        rx_n     = {rx_q[5:0], mosi_s};
        unique case (phase_q)
          PH_OPC: if (byte_done) begin
            op_n = dec;
            unique case (dec)
              OP_READ, OP_WRITE: phase_n = PH_ADH;
              OP_RDSR: begin phase_n = PH_RD; load_n = 1'b1; end
              OP_WRSR: phase_n = PH_WR;
              default: phase_n = PH_SKIP;
            endcase
          end
          PH_ADH: begin
            addr_n = {addr_q[AW-2:0], mosi_s};
            if (byte_done) phase_n = PH_ADL;
          end
          PH_ADL: begin
            addr_n = {addr_q[AW-2:0], mosi_s};
            if (byte_done) begin
              if (op_q == OP_READ) begin phase_n = PH_RD; load_n = 1'b1; end
              else phase_n = PH_WR;
            end
          end
          PH_WR: buf_push = byte_done;
          default: ;
        endcase
      end
      if (sck_fall && tx_live_q) begin
        miso_n  = tx_q[7];
        tx_n    = {tx_q[6:0], 1'b0};
        txcnt_n = txcnt_q + 3'd1;
        if (txcnt_q == 3'd7) begin
          load_n = 1'b1;
          if (op_q == OP_READ) addr_n = addr_q + AW'(1);
        end
      end
      if (load_q) begin
        tx_n = (op_q == OP_RDSR) ? stat_rdata : mem_rdata;
        tx_live_n = 1'b1;  txcnt_n = '0;  load_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      phase_q <= PH_OPC;  op_q <= OP_NONE;  bitcnt_q <= '0;
      txcnt_q <= '0;      rx_q <= '0;       tx_q <= '0;
      addr_q <= '0;       miso_q <= 1'b0;   tx_live_q <= 1'b0;
      load_q <= 1'b0;     wel_q <= 1'b0;    cm_busy_q <= 1'b0;
      cm_idx_q <= '0;     cm_cnt_q <= '0;   cm_base_q <= '0;
      stat_we_q <= 1'b0;
    end else begin
      phase_q <= phase_n;  op_q <= op_n;    bitcnt_q <= bitcnt_n;
      txcnt_q <= txcnt_n;  rx_q <= rx_n;    tx_q <= tx_n;
      addr_q <= addr_n;    miso_q <= miso_n; tx_live_q <= tx_live_n;
      load_q <= load_n;    wel_q <= wel_n;  cm_busy_q <= cm_busy_n;
      cm_idx_q <= cm_idx_n; cm_cnt_q <= cm_cnt_n; cm_base_q <= cm_base_n;
      stat_we_q <= stat_we_n;
    end
  end

  assign miso       = miso_q;
  assign miso_oe    = cs_act;
  assign wel        = wel_q;
  assign mem_raddr  = addr_q;
  assign mem_we     = cm_busy_q && prot_ok;
  assign mem_waddr  = cm_base_q + AW'(cm_idx_q);
  assign mem_wdata  = buf_rdata;
  assign stat_we    = stat_we_q;
  assign stat_wdata = buf_rdata;

  // R11
  stat_we_wel_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    stat_we_q |-> (!wel_q && $past(wel_q)));

  // R8
  commit_disarm_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(cm_busy_q) |-> !wel_q);

  // R9
  partial_byte_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_end && bitcnt_q != 3'd0 && !cm_busy_q) |=>
      (!cm_busy_q && !stat_we_q && $stable(wel_q)));

  // R4
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (cs_end && bitcnt_q == 3'd0 && op_q == OP_WRDI) |=> !wel_q);

  // R2
  deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cs_end |=> (!miso_q && !tx_live_q));

endmodule

// File: tb/tb_spi_mem_engine.sv
module tb_spi_mem_engine;

  localparam int HP = 6;

  logic        clk, rst_n, sck, cs_n, mosi;
  logic        miso, miso_oe, wel, mem_we, prot_ok, stat_we, stat_wr_ok;
  logic [12:0] mem_raddr, mem_waddr;
  logic [7:0]  mem_rdata, mem_wdata, stat_rdata, stat_wdata, stat_q;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [7:0]  mem_m [int];
  logic [20:0] exp_wr_q [$];
  string       exp_wr_tag [$];
  logic [7:0]  exp_rd_q [$];
  string       exp_rd_tag [$];
  logic [7:0]  got_q [$];

  spi_mem_engine dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .wel(wel), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .prot_ok(prot_ok), .stat_rdata(stat_rdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_wr_ok(stat_wr_ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] mval(input int a);
    if (mem_m.exists(a)) return mem_m[a];
    return 8'(a * 7 + 3);
  endfunction

  // protection unit: top quarter refused
  assign prot_ok    = (mem_waddr < 13'h1800);
  assign stat_rdata = {stat_q[7:2], wel, 1'b0};

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // array model, status model and write monitor
  always @(negedge clk) begin
    if (!rst_n) stat_q <= 8'h00;
    else if (stat_we) stat_q <= stat_wdata;
    if (rst_n && mem_we) begin
      if (exp_wr_q.size() == 0) begin
        chk(0, "R5/R9/R12 unexpected write", {11'd0, mem_waddr, mem_wdata}, 0);
      end else begin
        logic [20:0] e;
        string t;
        e = exp_wr_q.pop_front();
        t = exp_wr_tag.pop_front();
        chk({mem_waddr, mem_wdata} == e, t, {mem_waddr, mem_wdata}, e);
      end
      mem_m[int'(mem_waddr)] = mem_wdata;
    end
    mem_rdata <= mval(int'(mem_raddr));
  end

  // read monitor
  always @(negedge clk) begin
    if (got_q.size() > 0 && exp_rd_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_rd_q.pop_front();
      t = exp_rd_tag.pop_front();
      chk(g == e, t, g, e);
    end
  end

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    clks(HP);
    chk(miso_oe == 1'b1, "R2 oe while selected", miso_oe, 1);
  endtask

  task automatic desel();
    clks(HP);
    cs_n = 1'b1;
    clks(60);
  endtask

  task automatic bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      mosi = tx[i];
      clks(HP);
      rx[i] = miso;
      sck = 1'b1;
      clks(HP);
      sck = 1'b0;
    end
  endtask

  // send one byte; when chk_it, queue the expected reply for the monitor
  task automatic xb(input logic [7:0] tx, input bit chk_it, input logic [7:0] exp,
                    input string req);
    logic [7:0] rx;
    if (chk_it) begin
      exp_rd_q.push_back(exp);
      exp_rd_tag.push_back(req);
    end
    bits(tx, 8, rx);
    if (chk_it) got_q.push_back(rx);
  endtask

  task automatic cmd(input logic [7:0] op);
    sel();
    xb(op, 0, 0, "");
    desel();
  endtask

  task automatic rd_stream(input logic [7:0] op, input logic [15:0] a, input int n,
                           input string req);
    sel();
    xb(op, 0, 0, "");
    xb(a[15:8], 0, 0, "");
    xb(a[7:0], 0, 0, "");
    for (int i = 0; i < n; i++)
      xb(8'h00, 1, mval(int'((a + 16'(i)) & 16'h1FFF)), req);
    desel();
  endtask

  task automatic wr_array(input logic [15:0] a, input int n, input logic [7:0] base,
                          input bit expect_commit, input string req);
    if (expect_commit)
      for (int i = 0; i < n && i < 32; i++) begin
        logic [12:0] wa;
        wa = 13'((a + 16'(i)) & 16'h1FFF);
        if (wa < 13'h1800) begin
          exp_wr_q.push_back({wa, base + 8'(i)});
          exp_wr_tag.push_back(req);
        end
      end
    sel();
    xb(8'h02, 0, 0, "");
    xb(a[15:8], 0, 0, "");
    xb(a[7:0], 0, 0, "");
    for (int i = 0; i < n; i++) xb(base + 8'(i), 0, 0, "");
    desel();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "R1 watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] rx;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; mosi = 1'b0; stat_wr_ok = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(5);
    // R1 reset state
    chk(wel == 1'b0, "R1 wel after reset", wel, 0);
    chk(miso_oe == 1'b0, "R1 oe after reset", miso_oe, 0);
    chk(mem_we == 1'b0 && stat_we == 1'b0, "R1 no write", mem_we, 0);

    // R5 unarmed write is dropped
    wr_array(16'h0010, 2, 8'hAA, 0, "R5");
    chk(miso_oe == 1'b0, "R2 oe after deselect", miso_oe, 0);
    rd_stream(8'h03, 16'h0010, 2, "R5 data untouched");

    // R3/R4 arm, status read with bit 3 set, disarm with bit 3 set
    cmd(8'h06);
    chk(wel == 1'b1, "R4 arm", wel, 1);
    sel();
    xb(8'h0D, 0, 0, "");
    xb(8'h00, 1, 8'h02, "R3 status read bit3 set");
    xb(8'h00, 1, 8'h02, "R11 status repeats");
    desel();
    cmd(8'h0C);
    chk(wel == 1'b0, "R4 disarm ignores stat_wr_ok", wel, 0);
    sel();
    xb(8'h05, 0, 0, "");
    xb(8'h00, 1, 8'h00, "R3 status read");
    desel();

    // R8/R6 armed write then read back with upper address bits set
    cmd(8'h06);
    wr_array(16'h0100, 3, 8'h11, 1, "R8 commit");
    chk(wel == 1'b0, "R8 disarmed after commit", wel, 0);
    rd_stream(8'h03, 16'hE100, 4, "R6 read stream");
    rd_stream(8'h0B, 16'h0101, 2, "R3 read bit3 set");

    // R7 wrap
    rd_stream(8'h03, 16'h1FFE, 4, "R7 wrap");

    // R9 partial byte
    cmd(8'h06);
    sel();
    xb(8'h02, 0, 0, "");
    xb(8'h02, 0, 0, "");
    xb(8'h00, 0, 0, "");
    xb(8'h55, 0, 0, "");
    bits(8'hF0, 4, rx);
    desel();
    chk(wel == 1'b1, "R9 wel kept", wel, 1);
    rd_stream(8'h03, 16'h0200, 1, "R9 no write");

    // R10 grant refusal
    wr_array(16'h17FF, 2, 8'h01, 1, "R10 grant");
    rd_stream(8'h03, 16'h17FF, 2, "R10 read back");

    // R13 overflow
    cmd(8'h06);
    wr_array(16'h0300, 34, 8'h40, 1, "R13 overflow");
    rd_stream(8'h03, 16'h031F, 3, "R13 read back");

    // R11 status write granted then refused
    cmd(8'h06);
    stat_wr_ok = 1'b1;
    sel(); xb(8'h01, 0, 0, ""); xb(8'h8C, 0, 0, ""); desel();
    chk(stat_q == 8'h8C, "R11 status written", stat_q, 8'h8C);
    chk(wel == 1'b0, "R11 disarm", wel, 0);
    cmd(8'h06);
    stat_wr_ok = 1'b0;
    sel(); xb(8'h09, 0, 0, ""); xb(8'h00, 0, 0, ""); desel();
    chk(wel == 1'b0, "R11 disarm when refused", wel, 0);
    sel(); xb(8'h05, 0, 0, ""); xb(8'h00, 1, 8'h8C, "R11 refused write"); desel();

    // R12 unknown opcodes
    cmd(8'h06);
    sel();
    xb(8'h12, 0, 0, "");
    xb(8'h00, 1, 8'h00, "R12 quiet output");
    xb(8'h40, 1, 8'h00, "R12 quiet output");
    xb(8'h99, 1, 8'h00, "R12 quiet output");
    desel();
    cmd(8'h07);
    chk(wel == 1'b1, "R12 wel unchanged", wel, 1);
    rd_stream(8'h03, 16'h0040, 1, "R12 no write");
    cmd(8'h04);

    clks(20);
    chk(exp_wr_q.size() == 0, "R8 all writes seen", exp_wr_q.size(), 0);
    chk(exp_rd_q.size() == 0, "R6 all reads seen", exp_rd_q.size(), 0);
    finish_run();
  end

endmodule